// File: doc/BRIEF.md
# Seven-Pin General-Purpose I/O Controller

This block manages seven general-purpose pins from two byte-wide configuration registers. The direction register decides, pin by pin, whether the pad is read or driven. A second register holds one bit per pin, and what that bit does depends on the direction. On an input pin it sets the active level. On an output pin it chooses between push-pull drive and open-drain drive.

The core reaches the block through a simple register port: a write strobe, an address and write data, plus a read-data bus that follows the address. On the pad side, each pin has an input value, an output value and an output enable. The core supplies the data to drive and receives the input values with the polarity already corrected, so a 1 always means asserted. Input pads pass through a two-stage synchronizer before that correction is applied.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After synchronous reset, the direction register reads 0x00 and the polarity/type register reads 0x7F.
- R2: A write with reg_wr_en high at a rising edge updates the addressed register at that edge. Address 0 selects direction and address 1 selects polarity/type. Bit n of either register belongs to pin n for n = 0..6. reg_rdata shows the addressed register in the same cycle, without a clock edge.
- R3: Bit 7 of both registers ignores writes and always reads 0. Any address other than 0 and 1 reads 0x00, and a write to such an address changes neither register.
- R4: A pin whose direction bit is 0 (input) never asserts pad_oe and drives pad_out to 0.
- R5: A pin with direction 1 and polarity/type 0 (push-pull) holds pad_oe at 1, and pad_out equals its core_out bit.
- R6: A pin with direction 1 and polarity/type 1 (open-drain) has pad_oe equal to the inverse of its core_out bit and pad_out at 0. It never drives a 1 onto the pad.
- R7: For an input pin, core_in equals the synchronized pad value when polarity/type is 1 (active high) and its inverse when polarity/type is 0 (active low).
- R8: For an output pin, the core_in bit is 0.
- R9: A change on pad_in first reaches core_in after the second rising edge following the change. It is not visible after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| pad_in | input | 7 | Raw input level from each pad |
| pad_out | output | 7 | Value driven to each pad |
| pad_oe | output | 7 | Output enable for each pad |
| core_out | input | 7 | Data from the core for output pins |
| core_in | output | 7 | Synchronized, polarity-corrected input to the core |

## Verification
Pad drive and read data are combinational in the registers and core_out. The bench therefore samples them at the falling edge that follows a register write, or shortly after a core_out change in the same low phase. Input results take two rising edges. Each random round holds pad_in for two full edges before core_in is compared. A directed case also samples core_in after only one edge and confirms that the old value is still present, which pins the latency at exactly two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    parameter int GPIO_PINS   = 7;
    parameter int GPIO_REG_W  = 8;
    parameter int GPIO_ADDR_W = 4;
    parameter int GPIO_SYNC_N = 2;

    localparam logic [GPIO_ADDR_W-1:0] ADDR_DIRECTION = 'd0;
    localparam logic [GPIO_ADDR_W-1:0] ADDR_POLTYPE   = 'd1;

    typedef enum logic [1:0] {
        PIN_INPUT      = 2'd0,
        PIN_PUSH_PULL  = 2'd1,
        PIN_OPEN_DRAIN = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic is_output;
        logic pol_type;
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drive_t;

    function automatic pin_mode_e decode_mode(input pin_cfg_t cfg);
        if (!cfg.is_output)
            return PIN_INPUT;
        else if (cfg.pol_type)
            return PIN_OPEN_DRAIN;
        else
            return PIN_PUSH_PULL;
    endfunction

    function automatic pad_drive_t drive_for(input pin_mode_e mode, input logic data);
        pad_drive_t d;
        case (mode)
            PIN_PUSH_PULL:  begin d.oe = 1'b1;  d.val = data; end
            PIN_OPEN_DRAIN: begin d.oe = ~data; d.val = 1'b0; end
            default:        begin d.oe = 1'b0;  d.val = 1'b0; end
        endcase
        return d;
    endfunction

    function automatic logic asserted_level(input logic raw, input logic active_high);
        return active_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = GPIO_PINS,
    parameter int REG_W    = GPIO_REG_W,
    parameter int ADDR_W   = GPIO_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] pt_q
);
    localparam int RSV_W = REG_W - NUM_PINS;
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_PT  = ADDR_W'(1);

    logic hit_dir;
    logic hit_pt;

    assign hit_dir = wr_en && (addr == A_DIR);
    assign hit_pt  = wr_en && (addr == A_PT);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            pt_q  <= '1;
        end else begin
            if (hit_dir) dir_q <= wdata[NUM_PINS-1:0];
            if (hit_pt)  pt_q  <= wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        case (addr)
            A_DIR:   rdata = {{RSV_W{1'b0}}, dir_q};
            A_PT:    rdata = {{RSV_W{1'b0}}, pt_q};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 7,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] async_in,
    output logic [NUM_PINS-1:0] sync_out
);
    logic [STAGES-1:0][NUM_PINS-1:0] stage_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = GPIO_PINS
) (
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] pt_q,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] sync_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] core_in
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_cfg_t   cfg;
        pin_mode_e  mode;
        pad_drive_t drv;

        always_comb begin
            cfg.is_output = dir_q[p];
            cfg.pol_type  = pt_q[p];
            mode          = decode_mode(cfg);
            drv           = drive_for(mode, core_out[p]);
        end

        assign pad_oe[p]  = drv.oe;
        assign pad_out[p] = drv.val;
        assign core_in[p] = (mode == PIN_INPUT) ? asserted_level(sync_in[p], cfg.pol_type) : 1'b0;
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = GPIO_PINS,
    parameter int REG_W    = GPIO_REG_W,
    parameter int ADDR_W   = GPIO_ADDR_W,
    parameter int SYNC_N   = GPIO_SYNC_N
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] core_out,
    output logic [NUM_PINS-1:0] core_in
);
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] pt_q;
    logic [NUM_PINS-1:0] sync_in;

    gpio_cfg_regs #(
        .NUM_PINS (NUM_PINS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .dir_q (dir_q),
        .pt_q  (pt_q)
    );

    gpio_in_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_N)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (sync_in)
    );

    gpio_pad_drive #(
        .NUM_PINS (NUM_PINS)
    ) u_drive (
        .dir_q    (dir_q),
        .pt_q     (pt_q),
        .core_out (core_out),
        .sync_in  (sync_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .core_in  (core_in)
    );

endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk #(
    parameter int NUM_PINS = 7,
    parameter int REG_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] pt_q,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] core_out,
    input logic [NUM_PINS-1:0] core_in,
    input logic [REG_W-1:0]    reg_rdata
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_CFG: assert property (@(posedge clk) rst |=> (dir_q == '0 && pt_q == '1)); // R1
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst) reg_rdata[REG_W-1] == 1'b0); // R3
    AST_INPUT_NO_OE: assert property (@(posedge clk) disable iff (rst) ((pad_oe | pad_out) & ~dir_q) == '0); // R4
    AST_PP_DRIVES: assert property (@(posedge clk) disable iff (rst) ((dir_q & ~pt_q) & ~(pad_oe & ~(pad_out ^ core_out))) == '0); // R5
    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst) (pad_oe & pad_out & dir_q & pt_q) == '0); // R6
    AST_OUT_CORE_ZERO: assert property (@(posedge clk) disable iff (rst) (core_in & dir_q) == '0); // R8
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (core_in == (($past(pad_in, 2) ^ ~pt_q) & ~dir_q))); // R9

endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .REG_W    (REG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dir_q     (dir_q),
    .pt_q      (pt_q),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .core_out  (core_out),
    .core_in   (core_in),
    .reg_rdata (reg_rdata)
);

// File: tb/gpio_pin_ctrl_test.sv
module gpio_pin_ctrl_test;
    localparam int NP = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_wr_en;
    logic [3:0]    reg_addr;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] core_out;
    logic [NP-1:0] core_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gpio_pin_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .core_out  (core_out),
        .core_in   (core_in)
    );

    function automatic logic [NP-1:0] exp_oe(input logic [NP-1:0] d, input logic [NP-1:0] p,
                                             input logic [NP-1:0] c);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = !d[i] ? 1'b0 : (p[i] ? ~c[i] : 1'b1);
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_out(input logic [NP-1:0] d, input logic [NP-1:0] p,
                                              input logic [NP-1:0] c);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = (d[i] && !p[i]) ? c[i] : 1'b0;
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_cin(input logic [NP-1:0] d, input logic [NP-1:0] p,
                                              input logic [NP-1:0] raw);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = d[i] ? 1'b0 : (p[i] ? raw[i] : ~raw[i]);
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pad_check(input string req, input logic [NP-1:0] d, input logic [NP-1:0] p);
        #1;
        check({req, " oe"},  {1'b0, pad_oe},  {1'b0, exp_oe(d, p, core_out)});
        check({req, " out"}, {1'b0, pad_out}, {1'b0, exp_out(d, p, core_out)});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] d, p, raw_old;
        void'($urandom(32'd4242));
        rst = 1'b1; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        pad_in = '0; core_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_check("R1 dir", 4'd0, 8'h00);
        rd_check("R1 pt", 4'd1, 8'h7F);

        // R2 write/readback
        wr(4'd0, 8'h55);
        rd_check("R2 dir", 4'd0, 8'h55);
        wr(4'd1, 8'h2A);
        rd_check("R2 pt", 4'd1, 8'h2A);

        // R3 reserved bit and unmapped addresses
        wr(4'd0, 8'hFF);
        rd_check("R3 dir bit7", 4'd0, 8'h7F);
        wr(4'd1, 8'h80);
        rd_check("R3 pt bit7", 4'd1, 8'h00);
        wr(4'd5, 8'h3C);
        rd_check("R3 unmapped", 4'd5, 8'h00);
        rd_check("R3 dir untouched", 4'd0, 8'h7F);
        rd_check("R3 pt untouched", 4'd1, 8'h00);

        // R5 push-pull: all outputs, type 0
        core_out = 7'h35;
        pad_check("R5 pp", 7'h7F, 7'h00);
        core_out = 7'h4A;
        pad_check("R5 pp", 7'h7F, 7'h00);

        // R6 open-drain
        wr(4'd1, 8'h7F);
        core_out = 7'h0F;
        pad_check("R6 od", 7'h7F, 7'h7F);
        // R8 output pins report 0
        pad_in = 7'h7F;
        repeat (3) @(negedge clk);
        #1 check("R8 core_in", {1'b0, core_in}, 8'h00);

        // R4 inputs never drive
        wr(4'd0, 8'h00);
        core_out = 7'h7F;
        pad_check("R4 in", 7'h00, 7'h7F);

        // R7 active high then low
        pad_in = 7'h1B;
        repeat (2) @(negedge clk);
        #1 check("R7 high", {1'b0, core_in}, {1'b0, 7'h1B});
        wr(4'd1, 8'h00);
        #1 check("R7 low", {1'b0, core_in}, {1'b0, ~7'h1B});

        // R9 latency: visible after second edge, not first
        wr(4'd1, 8'h7F);
        @(negedge clk);
        pad_in = 7'h64;
        @(negedge clk);
        #1 check("R9 one edge", {1'b0, core_in}, {1'b0, 7'h1B});
        @(negedge clk);
        #1 check("R9 two edges", {1'b0, core_in}, {1'b0, 7'h64});

        // Random rounds: R4 R5 R6 R7 R8
        for (int it = 0; it < 300; it++) begin
            d = NP'($urandom);
            p = NP'($urandom);
            wr(4'd0, {1'b0, d});
            wr(4'd1, {1'b0, p});
            core_out = NP'($urandom);
            raw_old  = NP'($urandom);
            pad_in   = raw_old;
            pad_check("R4-6 rand drive", d, p);
            repeat (2) @(negedge clk);
            #1 check("R7/R8 rand core_in", {1'b0, core_in}, {1'b0, exp_cin(d, p, raw_old)});
            rd_check("R2 rand dir", 4'd0, {1'b0, d});
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule